// File: doc/BRIEF.md
# Synchronous Serial Master with Word FIFOs

This block drives a four-wire style serial link as the clocking master. Software writes transfer words into an eight-entry transmit queue through a small register port. A shift engine sends each queued word most-significant bit first. It returns the word captured on the input line into an eight-entry receive queue, one received word for every word sent. Reading a word therefore means sending a filler word of all ones and then popping the receive queue. Chip select is left to logic outside the block.

The serial bit clock comes from two dividers in a row. An even prescaler of 2 to 254 comes first, and a rate divider of 1 to 256 follows it. Word length can be set anywhere from 4 to 16 bits. Clock polarity and clock phase can be set separately, which gives the four usual modes. The shift engine is a three-state machine. IDLE holds the clock at its rest level. LEAD is the first half of a bit and TRAIL is the second half. The transitions are named as follows:
- start (IDLE to LEAD) pops the transmit queue when the engine is enabled and a word is waiting.
- sample (LEAD to TRAIL) captures the input bit.
- next_bit (TRAIL to LEAD) shifts out the next bit.
- chain (TRAIL to LEAD on the last bit) loads the next queued word with no gap.
- finish (TRAIL to IDLE) ends the run when the queue is empty or the engine is disabled.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset both queues are empty and the enable bit is clear. The configuration word reads 0x0007 (8-bit words, polarity 0, phase 0, rate 0), the prescaler reads 2 and the status word reads 0x0003.
- R2: A prescaler write (address 4, bits 7:0) stores the value with bit 0 cleared, and a result below 2 is stored as 2. The stored value reads back at address 4.
- R3: Each half bit lasts (PRESCALE/2)×(RATE+1) clock cycles, so a word of n bits keeps the serial clock off its rest level for n×(PRESCALE/2)×(RATE+1) cycles. RATE is configuration bits 15:8.
- R4: Configuration bits 3:0 hold the word length minus one, and values below 3 are stored as 3. Words go out most-significant bit first. Only the low n bits of a written word are sent, and received words are right-justified with zeros above bit n−1.
- R5: Configuration bit 6 is polarity and bit 7 is phase, and the clock rests at the polarity level between words. With phase 0 the input is sampled on the first edge of each bit. With phase 1 it is sampled on the second edge. Each word produces exactly 2n clock edges.
- R6: Every word sent pushes exactly one received word into the receive queue, in order.
- R7: The control word (address 1) bit 0 enables transfers. While it is clear no transfer starts, even when the transmit queue holds words.
- R8: Both queues hold 8 words. A write of the data port (address 2) to a full transmit queue is dropped, a received word arriving at a full receive queue is dropped, and a read of an empty receive queue returns 0.
- R9: Status (address 3) has four bits: bit 0 transmit not full, bit 1 transmit empty, bit 2 receive not empty, and bit 3 busy. Busy is set while the transmit queue or the shift engine holds data.
- R10: Words waiting in the transmit queue are sent back to back. The time from the first to the last clock edge of k words of n bits is (2nk−1) half bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two things can happen in the same clock cycle. The shift engine can push a finished word into the receive queue while the register port pops the head of that queue. The register port can also push into the transmit queue while the engine pops it for a chained word. The bench provokes both cases by streaming eight chained words at the fastest bit rate while it polls status and drains the receive port. It judges the result on three counts: every word comes back once and in order, the ninth word written to the full transmit queue never appears, and the edge span shows no gap between words.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    localparam int DATA_W = 16;
    localparam int LEN_W  = 4;

    localparam logic [2:0] ADDR_CFG  = 3'd0;
    localparam logic [2:0] ADDR_CTRL = 3'd1;
    localparam logic [2:0] ADDR_DATA = 3'd2;
    localparam logic [2:0] ADDR_STAT = 3'd3;
    localparam logic [2:0] ADDR_PRE  = 3'd4;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_LEAD  = 2'd1,
        SH_TRAIL = 2'd2
    } sh_state_t;
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = empty ? '0 : mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end
endmodule

// File: rtl/sfm_clkdiv.sv
module sfm_clkdiv #(
    parameter int HALF_PRE_W = 7,
    parameter int RATE_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [HALF_PRE_W-1:0] half_pre,
    input  logic [RATE_W-1:0]     rate,
    output logic                  tick
);
    logic [HALF_PRE_W-1:0] pre_cnt;
    logic [RATE_W-1:0]     rate_cnt;
    logic                  pre_wrap;

    assign pre_wrap = (pre_cnt == half_pre - 1'b1);
    assign tick     = run && pre_wrap && (rate_cnt == rate);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
        end else if (!run) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt  <= '0;
            rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter
    import sfm_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int LW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [LW-1:0] len_m1,
    input  logic          tick,
    input  logic          tx_avail,
    input  logic [DW-1:0] tx_word,
    input  logic          miso,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          sclk,
    output logic          mosi,
    output logic          active
);
    sh_state_t     state, state_nx;
    logic [DW-1:0] tx_sh, rx_sh;
    logic [LW-1:0] bit_cnt;
    logic          last_bit, load;

    assign last_bit = (bit_cnt == len_m1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        rx_push  = 1'b0;
        unique case (state)
            SH_IDLE: begin
                if (enable && tx_avail) begin           // start
                    load     = 1'b1;
                    state_nx = SH_LEAD;
                end
            end
            SH_LEAD: begin
                if (tick) state_nx = SH_TRAIL;          // sample
            end
            SH_TRAIL: begin
                if (tick) begin
                    if (!last_bit) begin
                        state_nx = SH_LEAD;             // next_bit
                    end else begin
                        rx_push = 1'b1;
                        if (enable && tx_avail) begin   // chain
                            load     = 1'b1;
                            state_nx = SH_LEAD;
                        end else begin
                            state_nx = SH_IDLE;         // finish
                        end
                    end
                end
            end
            default: state_nx = SH_IDLE;
        endcase
        tx_pop  = load;
        active  = (state != SH_IDLE);
        mosi    = active ? tx_sh[DW-1] : 1'b0;
        sclk    = cpol ^ (cpha ? (state == SH_LEAD) : (state == SH_TRAIL));
        rx_word = rx_sh & ({DW{1'b1}} >> (LW'(DW - 1) - len_m1));
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else begin
            if (load) begin
                tx_sh   <= tx_word << (LW'(DW - 1) - len_m1);
                bit_cnt <= '0;
            end else if (state == SH_TRAIL && tick && !last_bit) begin
                tx_sh   <= tx_sh << 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == SH_LEAD && tick) rx_sh <= {rx_sh[DW-2:0], miso};
        end
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import sfm_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int PRE_W      = 8,
    parameter int RATE_W     = 8,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    logic [LEN_W-1:0]  cfg_len_m1;
    logic              cfg_cpol, cfg_cpha, ctrl_en;
    logic [RATE_W-1:0] cfg_rate;
    logic [PRE_W-1:0]  prescale_q, pre_in;

    logic wr_cfg, wr_ctrl, wr_data, wr_pre, rd_data;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic tx_empty, tx_full, rx_empty, rx_full, tx_pop, rx_push;
    logic [CW-1:0] tx_count, rx_count;
    logic sh_active, tick, status_busy;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[5:4], rx_full};

    assign wr_cfg  = bus_sel && bus_wr && (bus_addr == ADDR_CFG);
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
    assign wr_pre  = bus_sel && bus_wr && (bus_addr == ADDR_PRE);
    assign rd_data = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);

    assign pre_in = bus_wdata[PRE_W-1:0] & ~PRE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_len_m1 <= LEN_W'(7);
            cfg_cpol   <= 1'b0;
            cfg_cpha   <= 1'b0;
            cfg_rate   <= '0;
            ctrl_en    <= 1'b0;
            prescale_q <= PRE_W'(2);
        end else begin
            if (wr_cfg) begin
                cfg_len_m1 <= (bus_wdata[3:0] < 4'd3) ? LEN_W'(3) : bus_wdata[3:0];
                cfg_cpol   <= bus_wdata[6];
                cfg_cpha   <= bus_wdata[7];
                cfg_rate   <= bus_wdata[8 +: RATE_W];
            end
            if (wr_ctrl) ctrl_en <= bus_wdata[0];
            if (wr_pre)  prescale_q <= (pre_in < PRE_W'(2)) ? PRE_W'(2) : pre_in;
        end
    end

    sfm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_data), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full),
        .count(tx_count)
    );

    sfm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
        .pop(rd_data), .dout(rx_head), .empty(rx_empty), .full(rx_full),
        .count(rx_count)
    );

    sfm_clkdiv #(.HALF_PRE_W(PRE_W - 1), .RATE_W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(sh_active),
        .half_pre(prescale_q[PRE_W-1:1]), .rate(cfg_rate), .tick(tick)
    );

    sfm_shifter #(.DW(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_en), .cpol(cfg_cpol),
        .cpha(cfg_cpha), .len_m1(cfg_len_m1), .tick(tick),
        .tx_avail(!tx_empty), .tx_word(tx_head), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .active(sh_active)
    );

    assign status_busy = sh_active || !tx_empty;

    always_comb begin
        unique case (bus_addr)
            ADDR_CFG:  bus_rdata = {cfg_rate, cfg_cpha, cfg_cpol, 2'b00, cfg_len_m1};
            ADDR_CTRL: bus_rdata = {15'd0, ctrl_en};
            ADDR_DATA: bus_rdata = rx_head;
            ADDR_STAT: bus_rdata = {12'd0, status_busy, !rx_empty, tx_empty, !tx_full};
            ADDR_PRE:  bus_rdata = DATA_W'(prescale_q);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          sh_active,
    input logic          ctrl_en,
    input logic          cfg_cpol,
    input logic          sclk,
    input logic [7:0]    prescale_q
);
    assert_tx_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));

    assert_rx_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    assert_rest_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_active |-> (sclk == cfg_cpol));

    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !sh_active) |=> !sh_active);

    assert_start_has_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_active) |-> ($past(tx_count) != '0));

    assert_prescale_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale_q[0] == 1'b0) && (prescale_q >= 8'd2));
endmodule

bind spi_fifo_master sfm_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
    .sh_active(sh_active), .ctrl_en(ctrl_en), .cfg_cpol(cfg_cpol),
    .sclk(sclk), .prescale_q(prescale_q)
);

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi, miso;

    assign miso = mosi; // loopback

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_fifo_master u_spi_fifo_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0, n_fail = 0;

    // line monitor, sampled on the falling clock edge
    int          cyc = 0, edges = 0, active_cyc = 0, arm_base = 0;
    int          first_cyc = 0, last_cyc = 0;
    logic        prev_sclk = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
    logic [15:0] mon_word = '0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_sclk <= sclk;
        if (sclk !== mon_cpol) active_cyc <= active_cyc + 1;
        if (rst_n && sclk !== prev_sclk) begin
            if (edges == arm_base) first_cyc <= cyc;
            last_cyc <= cyc;
            edges <= edges + 1;
            if (sclk == (mon_cpol ^ mon_cpha ^ 1'b1)) mon_word <= {mon_word[14:0], mosi};
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd3, s);
            if (!s[3]) break;
        end
    endtask

    task automatic reset_checks(input string tag);
        logic [15:0] v;
        rd(3'd0, v); chk({tag, " R1 cfg"}, v, 16'h0007);
        rd(3'd1, v); chk({tag, " R1 ctrl"}, v, 0);
        rd(3'd3, v); chk({tag, " R1 R9 status"}, v, 16'h0003);
        rd(3'd4, v); chk({tag, " R1 prescale"}, v, 2);
        rd(3'd2, v); chk({tag, " R8 empty read"}, v, 0);
    endtask

    // {len(5), cpol, cpha, prescale written(8), rate(8), word(16)}
    localparam int NV = 6;
    localparam logic [38:0] VECS [NV] = '{
        {5'd8,  1'b0, 1'b0, 8'd2, 8'd0, 16'h00A5},
        {5'd8,  1'b1, 1'b1, 8'd4, 8'd1, 16'h003C},
        {5'd4,  1'b0, 1'b1, 8'd5, 8'd0, 16'hFFF9},
        {5'd16, 1'b1, 1'b0, 8'd0, 8'd2, 16'hC3A1},
        {5'd12, 1'b0, 1'b0, 8'd6, 8'd0, 16'h5ABC},
        {5'd7,  1'b1, 1'b1, 8'd3, 8'd3, 16'h0055}
    };

    initial begin
        logic [15:0] v;
        logic [15:0] got [8];
        int ngot;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_checks("reset");

        for (int k = 0; k < NV; k++) begin
            int n, pre_eff, rate, half, e0, a0;
            logic cp, ph;
            logic [7:0]  pw;
            logic [15:0] w, mask;
            {n, cp, ph, pw, rate, w} = {27'd0, VECS[k][38:34], VECS[k][33], VECS[k][32],
                                        VECS[k][31:24], 24'd0, VECS[k][23:16], VECS[k][15:0]};
            n    = int'(VECS[k][38:34]);
            cp   = VECS[k][33];
            ph   = VECS[k][32];
            pw   = VECS[k][31:24];
            rate = int'(VECS[k][23:16]);
            w    = VECS[k][15:0];
            pre_eff = ((pw & 8'hFE) < 2) ? 2 : int'(pw & 8'hFE);
            half = (pre_eff / 2) * (rate + 1);
            mask = 16'hFFFF >> (16 - n);
            mon_cpol = cp; mon_cpha = ph;
            wr(3'd0, {rate[7:0], ph, cp, 2'b00, 4'(n - 1)});
            wr(3'd4, {8'd0, pw});
            rd(3'd4, v); chk($sformatf("R2 prescale vec%0d", k), v, pre_eff);
            wr(3'd1, 16'h0001);
            @(negedge clk);
            e0 = edges; a0 = active_cyc; arm_base = edges;
            wr(3'd2, w);
            wait_idle();
            @(negedge clk);
            rd(3'd2, v);
            chk($sformatf("R4 R6 rx word vec%0d", k), v, w & mask);
            chk($sformatf("R5 sampled line vec%0d", k), mon_word & mask, w & mask);
            chk($sformatf("R5 edge count vec%0d", k), edges - e0, 2 * n);
            chk($sformatf("R3 active cycles vec%0d", k), active_cyc - a0, n * half);
            chk($sformatf("R3 edge span vec%0d", k), last_cyc - first_cyc, (2 * n - 1) * half);
            chk($sformatf("R5 rest level vec%0d", k), sclk, cp);
            wr(3'd1, 16'h0000);
        end

        // R7 / R8 / R10: enable gate, full transmit queue, chained words, concurrent drain
        begin
            int e0;
            mon_cpol = 1'b1; mon_cpha = 1'b0;
            wr(3'd0, 16'h0047);
            wr(3'd4, 16'h0002);
            for (int i = 0; i < 9; i++) wr(3'd2, 16'(8'h11 + i));
            e0 = edges;
            repeat (20) @(negedge clk);
            chk("R7 no edges while disabled", edges - e0, 0);
            chk("R7 R5 clock at rest", sclk, 1);
            rd(3'd3, v); chk("R9 R8 status full and disabled", v, 16'h0008);
            arm_base = edges;
            wr(3'd1, 16'h0001);
            ngot = 0;
            for (int g = 0; g < 400 && ngot < 8; g++) begin
                rd(3'd3, v);
                if (v[2]) begin
                    rd(3'd2, v);
                    got[ngot] = v;
                    ngot++;
                end
            end
            wait_idle();
            chk("R6 words returned", ngot, 8);
            for (int i = 0; i < 8; i++)
                chk($sformatf("R6 R8 order word%0d", i), got[i], 8'h11 + i);
            chk("R10 chained edge span", last_cyc - first_cyc, 2 * 8 * 8 - 1);
            chk("R10 chained edge count", edges - e0, 128);
            rd(3'd2, v); chk("R8 drained read is zero", v, 0);
        end

        // R8: receive queue overflow drops the newest word
        begin
            for (int i = 0; i < 8; i++) wr(3'd2, 16'(8'h30 + i));
            wait_idle();
            wr(3'd2, 16'h0077);
            wait_idle();
            rd(3'd3, v); chk("R9 status rx full idle", v, 16'h0007);
            for (int i = 0; i < 8; i++) begin
                rd(3'd2, v);
                chk($sformatf("R8 rx kept word%0d", i), v, 8'h30 + i);
            end
            rd(3'd2, v); chk("R8 overflow word dropped", v, 0);
        end

        // R4: illegal short length clamps to 4 bits
        begin
            mon_cpol = 1'b0; mon_cpha = 1'b0;
            wr(3'd0, 16'h0001);
            rd(3'd0, v); chk("R4 length clamp", v, 16'h0003);
        end

        // R1: reset after traffic
        wr(3'd0, 16'h13C5);
        wr(3'd2, 16'h00AA);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        reset_checks("re-reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule